// File: doc/BRIEF.md
# DRAM Spare Row Remapping Engine

This block sits between the activate decoder of a DRAM bank group and the row drivers. Every activate carries a bank and a row address. The block compares that address with a table of repair entries. When an entry matches, the normal row select is held off and the index of the spare row bound to that entry is driven instead. The decision is registered, so the select outputs follow the activate by one clock cycle.

The table holds two kinds of entry. Soft entries are volatile registers, a fixed number per bank. They clear on reset and can be added, released and written again without limit. Hard entries model one-time-programmable fuses shared by the whole device. Once written they stay for good and ignore reset. An input named `otp_blank` stands for the blank fuse state of a new device and is asserted only at the first power-up.

A program port adds or releases entries and answers the next cycle with either done or error. A read port returns used and free counts and two saturating activation counters, one for hard hits and one for soft hits.

Top module: `spare_row_remap`

## Requirements
- R1: An activate hits only when a valid entry holds exactly the same bank and the same row. Exactly one cycle after each activate, exactly one of `row_sel_en` or `spare_sel_en` is high. With no activate, both are low in the next cycle.
- R2: On a hit, `row_sel_en` is low, `spare_sel_en` is high, and `spare_idx` carries the entry's index. On a miss, `row_sel_en` is high. `sel_bank`/`sel_row` repeat the activate address. `spare_is_hard` is high only for a hard hit.
- R3: When both a hard entry and a soft entry match, the hard entry wins: `spare_is_hard`=1 and `spare_idx` is the hard index.
- R4: Hard entries survive `rst_n`. A hard clear request (`prog_hard`=1, `prog_clear`=1) is rejected with `prog_err`. A hard write of an address already held is also rejected, and no fuse is used for it.
- R5: Soft entries all clear on reset. A soft clear of a held address frees its slot, and that slot can be reused. A soft clear of an address not held is rejected.
- R6: A new soft write takes the lowest free slot of its bank, and `spare_idx` is that slot number (0 to SOFT_PER_BANK-1). A soft write of an address already held in the bank succeeds in place and uses no further slot.
- R7: A soft write to a bank whose slots are all used is rejected with `prog_err`. The table is left unchanged, so that address still misses.
- R8: A hard write takes the lowest unused fuse index. Once all HARD_ENTRIES fuses are used, a further hard write is rejected.
- R9: `rd_data` selected by `rd_sel` returns: 0 hard used, 1 hard free, 2 soft used in `rd_bank`, 3 soft free in `rd_bank`, 4 hard hit count, 5 soft hit count. After reset the soft counts are 0 used / SOFT_PER_BANK free.
- R10: The hard hit counter and the soft hit counter each add one per hit of their kind (a hard-over-soft hit counts as hard only). They stop at 2^CNT_W-1 and clear on reset.
- R11: One cycle after `prog_valid`, exactly one of `prog_done` or `prog_err` is high. Both are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (volatile state only) |
| otp_blank | input | 1 | Model of a blank fuse array; asserted once at first power-up |
| act_valid | input | 1 | Activate command strobe |
| act_bank | input | BANK_W | Activate bank address |
| act_row | input | ROW_W | Activate row address |
| row_sel_en | output | 1 | Normal row select enable (one cycle after activate) |
| spare_sel_en | output | 1 | Spare row select enable |
| spare_is_hard | output | 1 | Spare comes from a hard entry |
| spare_idx | output | SPARE_W | Index of the spare row selected |
| sel_bank | output | BANK_W | Registered activate bank |
| sel_row | output | ROW_W | Registered activate row |
| prog_valid | input | 1 | Program request strobe |
| prog_hard | input | 1 | 1 = hard entry, 0 = soft entry |
| prog_clear | input | 1 | 1 = release entry, 0 = write entry |
| prog_bank | input | BANK_W | Program bank address |
| prog_row | input | ROW_W | Program row address |
| prog_done | output | 1 | Request accepted (one cycle after) |
| prog_err | output | 1 | Request rejected (one cycle after) |
| rd_sel | input | 3 | Status read selector |
| rd_bank | input | BANK_W | Bank for soft counts |
| rd_data | output | CNT_W | Status read data |

## Verification
The bench targets these corner cases:
- Near-miss addresses, where only the bank or only the row matches. A design that compares only one of the two fields would remap the wrong rows.
- Rewriting an address that is already held. If that used up a second slot, the used count would drift and a bank would report full too early.
- A bank that is full. Writing the table anyway would overwrite a live repair.
- An address held by both a hard and a soft entry, where the wrong priority would route to the soft spare.
- A reset in the middle of a run. Losing the fuses there, or keeping the soft entries, shows up on the next activate.
- Long runs of hits that drive a hit counter past its limit. A counter that wraps would read back near zero.

// File: rtl/srr_pkg.sv
// Shared definitions for the spare row remapping engine.
// Assumes: read selector codes are fixed by the block's status interface.
package srr_pkg;

    typedef enum logic [2:0] {
        RD_HARD_USED = 3'd0,
        RD_HARD_FREE = 3'd1,
        RD_SOFT_USED = 3'd2,
        RD_SOFT_FREE = 3'd3,
        RD_HARD_HITS = 3'd4,
        RD_SOFT_HITS = 3'd5
    } rd_sel_e;

    // Index width for n items, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srr_soft_table.sv
// Volatile per-bank repair table.
// Each bank owns SOFT_PER_BANK slots, and each slot holds one row address.
// Lookup is combinational on the activate address. Programming adds an entry
// in the lowest free slot, keeps an existing match as is, or releases a
// matching entry. Assumes NUM_BANKS is a power of two and pg_wr/pg_clr are
// never both high.
module srr_soft_table #(
    parameter int NUM_BANKS     = 4,
    parameter int SOFT_PER_BANK = 4,
    parameter int ROW_W         = 14,
    localparam int BANK_W = srr_pkg::idx_bits(NUM_BANKS),
    localparam int SLOT_W = srr_pkg::idx_bits(SOFT_PER_BANK),
    localparam int UCNT_W = $clog2(SOFT_PER_BANK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    input  logic              pg_wr,
    input  logic              pg_clr,
    input  logic [BANK_W-1:0] pg_bank,
    input  logic [ROW_W-1:0]  pg_row,
    output logic              pg_ok,
    input  logic [BANK_W-1:0] st_bank,
    output logic [UCNT_W-1:0] st_used
);

    logic [SOFT_PER_BANK-1:0] vld_q [NUM_BANKS];
    logic [ROW_W-1:0]         row_q [NUM_BANKS][SOFT_PER_BANK];

    logic [SOFT_PER_BANK-1:0] lk_match;
    logic [SOFT_PER_BANK-1:0] pg_match;
    logic [SOFT_PER_BANK-1:0] pg_free;
    logic                     pg_hit;
    logic                     has_free;
    logic [SLOT_W-1:0]        hit_slot;
    logic [SLOT_W-1:0]        free_slot;
    logic                     do_add;
    logic                     do_rel;

    // One comparator pair per slot: activate path and program path.
    for (genvar s = 0; s < SOFT_PER_BANK; s++) begin : g_cmp
        assign lk_match[s] = vld_q[lk_bank][s] && (row_q[lk_bank][s] == lk_row);
        assign pg_match[s] = vld_q[pg_bank][s] && (row_q[pg_bank][s] == pg_row);
        assign pg_free[s]  = !vld_q[pg_bank][s];
    end

    // Encode the matching slot of the activate address.
    always_comb begin
        lk_hit  = |lk_match;
        lk_slot = '0;
        for (int s = SOFT_PER_BANK - 1; s >= 0; s--) begin
            if (lk_match[s]) lk_slot = SLOT_W'(s);
        end
    end

    // Encode the matching slot and the lowest free slot of the program bank.
    always_comb begin
        pg_hit    = |pg_match;
        has_free  = |pg_free;
        hit_slot  = '0;
        free_slot = '0;
        for (int s = SOFT_PER_BANK - 1; s >= 0; s--) begin
            if (pg_match[s]) hit_slot  = SLOT_W'(s);
            if (pg_free[s])  free_slot = SLOT_W'(s);
        end
    end

    assign do_add  = pg_wr && !pg_hit && has_free;
    assign do_rel  = pg_clr && pg_hit;
    assign pg_ok   = (pg_wr && (pg_hit || has_free)) || do_rel;
    assign st_used = UCNT_W'($countones(vld_q[st_bank]));

    // Slot valid bits: cleared by reset, set on add, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) vld_q[b] <= '0;
        end else if (do_rel) begin
            vld_q[pg_bank][hit_slot] <= 1'b0;
        end else if (do_add) begin
            vld_q[pg_bank][free_slot] <= 1'b1;
        end
    end

    // Slot row addresses: only meaningful while the slot is valid.
    always_ff @(posedge clk) begin
        if (do_add) row_q[pg_bank][free_slot] <= pg_row;
    end

endmodule

// File: rtl/srr_hard_store.sv
// Model of a one-time-programmable repair store shared by all banks.
// Entries are written once, in the lowest unused index, and never cleared.
// The store ignores the functional reset. Only otp_blank, which models the
// blank array of a new device, clears it. Assumes otp_blank is asserted once
// at first power-up only.
module srr_hard_store #(
    parameter int NUM_BANKS    = 4,
    parameter int HARD_ENTRIES = 1,
    parameter int ROW_W        = 14,
    localparam int BANK_W = srr_pkg::idx_bits(NUM_BANKS),
    localparam int HIDX_W = srr_pkg::idx_bits(HARD_ENTRIES),
    localparam int HCNT_W = $clog2(HARD_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              otp_blank,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_hit,
    output logic [HIDX_W-1:0] lk_idx,
    input  logic              pg_wr,
    input  logic [BANK_W-1:0] pg_bank,
    input  logic [ROW_W-1:0]  pg_row,
    output logic              pg_ok,
    output logic [HCNT_W-1:0] used
);

    logic [HARD_ENTRIES-1:0] fuse_q;
    logic [BANK_W-1:0]       fbank_q [HARD_ENTRIES];
    logic [ROW_W-1:0]        frow_q  [HARD_ENTRIES];

    logic [HARD_ENTRIES-1:0] lk_match;
    logic [HARD_ENTRIES-1:0] pg_match;
    logic [HIDX_W-1:0]       free_idx;

    // Full bank and row comparison per fuse entry.
    for (genvar i = 0; i < HARD_ENTRIES; i++) begin : g_cmp
        assign lk_match[i] = fuse_q[i] && (fbank_q[i] == lk_bank) && (frow_q[i] == lk_row);
        assign pg_match[i] = fuse_q[i] && (fbank_q[i] == pg_bank) && (frow_q[i] == pg_row);
    end

    // Encode the matching entry and the lowest unused entry.
    always_comb begin
        lk_idx   = '0;
        free_idx = '0;
        for (int i = HARD_ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) lk_idx   = HIDX_W'(i);
            if (!fuse_q[i])  free_idx = HIDX_W'(i);
        end
    end

    assign lk_hit = |lk_match;
    assign pg_ok  = pg_wr && !(|pg_match) && !(&fuse_q);
    assign used   = HCNT_W'($countones(fuse_q));

    // Fuse valid bits: blank at first power-up, set once, never cleared.
    always_ff @(posedge clk) begin
        if (otp_blank)  fuse_q <= '0;
        else if (pg_ok) fuse_q[free_idx] <= 1'b1;
    end

    // Fuse contents: written together with the valid bit.
    always_ff @(posedge clk) begin
        if (pg_ok && !otp_blank) begin
            fbank_q[free_idx] <= pg_bank;
            frow_q[free_idx]  <= pg_row;
        end
    end

endmodule

// File: rtl/srr_hit_counters.sv
// Bank of NUM saturating event counters, one increment strobe each.
// Assumes a synchronous active-low reset clears all counters.
module srr_hit_counters #(
    parameter int NUM   = 2,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);

    for (genvar k = 0; k < NUM; k++) begin : g_cnt
        // Count one event per cycle, holding at the all-ones value.
        always_ff @(posedge clk) begin
            if (!rst_n)                       cnt[k] <= '0;
            else if (inc[k] && !(&cnt[k]))    cnt[k] <= cnt[k] + 1'b1;
        end
    end

endmodule

// File: rtl/spare_row_remap.sv
// Spare row remapping engine for one DRAM bank group.
// It looks up each activate in the hard (fuse) store and in the soft
// (register) table, with hard taking priority. The decision is registered,
// so the select outputs follow act_valid by one cycle. The engine also
// handles program requests, answering one cycle later, and keeps a status
// read port with used/free counts and saturating hit counters.
// Assumes: NUM_BANKS is a power of two, SOFT_PER_BANK is in 2..8, and
// prog_valid requests are independent of activates.
module spare_row_remap #(
    parameter int NUM_BANKS     = 4,
    parameter int ROW_W         = 14,
    parameter int SOFT_PER_BANK = 4,
    parameter int HARD_ENTRIES  = 1,
    parameter int CNT_W         = 16,
    localparam int BANK_W  = srr_pkg::idx_bits(NUM_BANKS),
    localparam int SLOT_W  = srr_pkg::idx_bits(SOFT_PER_BANK),
    localparam int HIDX_W  = srr_pkg::idx_bits(HARD_ENTRIES),
    localparam int SPARE_W = (SLOT_W > HIDX_W) ? SLOT_W : HIDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               otp_blank,
    input  logic               act_valid,
    input  logic [BANK_W-1:0]  act_bank,
    input  logic [ROW_W-1:0]   act_row,
    output logic               row_sel_en,
    output logic               spare_sel_en,
    output logic               spare_is_hard,
    output logic [SPARE_W-1:0] spare_idx,
    output logic [BANK_W-1:0]  sel_bank,
    output logic [ROW_W-1:0]   sel_row,
    input  logic               prog_valid,
    input  logic               prog_hard,
    input  logic               prog_clear,
    input  logic [BANK_W-1:0]  prog_bank,
    input  logic [ROW_W-1:0]   prog_row,
    output logic               prog_done,
    output logic               prog_err,
    input  logic [2:0]         rd_sel,
    input  logic [BANK_W-1:0]  rd_bank,
    output logic [CNT_W-1:0]   rd_data
);
    import srr_pkg::*;

    localparam int UCNT_W = $clog2(SOFT_PER_BANK + 1);
    localparam int HCNT_W = $clog2(HARD_ENTRIES + 1);

    logic              soft_hit;
    logic [SLOT_W-1:0] soft_slot;
    logic              soft_ok;
    logic [UCNT_W-1:0] soft_used;
    logic              hard_hit;
    logic [HIDX_W-1:0] hard_idx;
    logic              hard_ok;
    logic [HCNT_W-1:0] hard_used;
    logic              soft_wr;
    logic              soft_clr;
    logic              hard_wr;
    logic              prog_ok;
    logic [1:0][CNT_W-1:0] hit_cnt;
    logic [CNT_W-1:0]  hard_hit_cnt;
    logic [CNT_W-1:0]  soft_hit_cnt;

    logic              vld_q;
    logic              hard_q;
    logic              soft_q;

    // Decode program requests into per-store operations.
    assign soft_wr  = prog_valid && !prog_hard && !prog_clear;
    assign soft_clr = prog_valid && !prog_hard &&  prog_clear;
    assign hard_wr  = prog_valid &&  prog_hard && !prog_clear;
    assign prog_ok  = soft_ok || hard_ok;

    srr_soft_table #(
        .NUM_BANKS    (NUM_BANKS),
        .SOFT_PER_BANK(SOFT_PER_BANK),
        .ROW_W        (ROW_W)
    ) u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_bank (act_bank),
        .lk_row  (act_row),
        .lk_hit  (soft_hit),
        .lk_slot (soft_slot),
        .pg_wr   (soft_wr),
        .pg_clr  (soft_clr),
        .pg_bank (prog_bank),
        .pg_row  (prog_row),
        .pg_ok   (soft_ok),
        .st_bank (rd_bank),
        .st_used (soft_used)
    );

    srr_hard_store #(
        .NUM_BANKS   (NUM_BANKS),
        .HARD_ENTRIES(HARD_ENTRIES),
        .ROW_W       (ROW_W)
    ) u_hard (
        .clk      (clk),
        .otp_blank(otp_blank),
        .lk_bank  (act_bank),
        .lk_row   (act_row),
        .lk_hit   (hard_hit),
        .lk_idx   (hard_idx),
        .pg_wr    (hard_wr),
        .pg_bank  (prog_bank),
        .pg_row   (prog_row),
        .pg_ok    (hard_ok),
        .used     (hard_used)
    );

    srr_hit_counters #(
        .NUM  (2),
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  ({act_valid && soft_hit && !hard_hit, act_valid && hard_hit}),
        .cnt  (hit_cnt)
    );

    assign hard_hit_cnt = hit_cnt[0];
    assign soft_hit_cnt = hit_cnt[1];

    // Register the remap decision and the address one cycle after activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q     <= 1'b0;
            hard_q    <= 1'b0;
            soft_q    <= 1'b0;
            spare_idx <= '0;
            sel_bank  <= '0;
            sel_row   <= '0;
        end else begin
            vld_q  <= act_valid;
            hard_q <= act_valid && hard_hit;
            soft_q <= act_valid && soft_hit && !hard_hit;
            if (act_valid) begin
                sel_bank  <= act_bank;
                sel_row   <= act_row;
                spare_idx <= hard_hit ? SPARE_W'(hard_idx) : SPARE_W'(soft_slot);
            end
        end
    end

    assign spare_sel_en  = hard_q || soft_q;
    assign spare_is_hard = hard_q;
    assign row_sel_en    = vld_q && !(hard_q || soft_q);

    // Register the program response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_done <= 1'b0;
            prog_err  <= 1'b0;
        end else begin
            prog_done <= prog_ok;
            prog_err  <= prog_valid && !prog_ok;
        end
    end

    // Status read multiplexer.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_HARD_USED: rd_data = CNT_W'(hard_used);
            RD_HARD_FREE: rd_data = CNT_W'(HARD_ENTRIES) - CNT_W'(hard_used);
            RD_SOFT_USED: rd_data = CNT_W'(soft_used);
            RD_SOFT_FREE: rd_data = CNT_W'(SOFT_PER_BANK) - CNT_W'(soft_used);
            RD_HARD_HITS: rd_data = hard_hit_cnt;
            RD_SOFT_HITS: rd_data = soft_hit_cnt;
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/srr_checker.sv
// Protocol checker for spare_row_remap, attached with bind.
// Assumes reset and otp_blank are each held for at least two cycles.
module srr_checker #(
    parameter int HCNT_W = 1,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              otp_blank,
    input logic              act_valid,
    input logic              row_sel_en,
    input logic              spare_sel_en,
    input logic              spare_is_hard,
    input logic              prog_valid,
    input logic              prog_hard,
    input logic              prog_clear,
    input logic              prog_done,
    input logic              prog_err,
    input logic [HCNT_W-1:0] hard_used,
    input logic [CNT_W-1:0]  hard_hit_cnt,
    input logic [CNT_W-1:0]  soft_hit_cnt
);

    assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_sel_en && spare_sel_en));

    assert_select_after_act_R1: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> (row_sel_en || spare_sel_en));

    assert_quiet_without_act_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |=> !(row_sel_en || spare_sel_en));

    assert_hard_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spare_is_hard |-> spare_sel_en);

    assert_prog_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |=> (prog_done != prog_err));

    assert_prog_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_valid |=> !(prog_done || prog_err));

    assert_hard_clear_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_valid && prog_hard && prog_clear) |=> prog_err);

    assert_fuse_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n || otp_blank)
        hard_used >= $past(hard_used));

    assert_hard_cnt_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hard_hit_cnt >= $past(hard_hit_cnt));

    assert_soft_cnt_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_hit_cnt >= $past(soft_hit_cnt));

endmodule

bind spare_row_remap srr_checker #(
    .HCNT_W(HCNT_W),
    .CNT_W (CNT_W)
) u_srr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .otp_blank    (otp_blank),
    .act_valid    (act_valid),
    .row_sel_en   (row_sel_en),
    .spare_sel_en (spare_sel_en),
    .spare_is_hard(spare_is_hard),
    .prog_valid   (prog_valid),
    .prog_hard    (prog_hard),
    .prog_clear   (prog_clear),
    .prog_done    (prog_done),
    .prog_err     (prog_err),
    .hard_used    (hard_used),
    .hard_hit_cnt (hard_hit_cnt),
    .soft_hit_cnt (soft_hit_cnt)
);

// File: tb/sim_spare_row_remap.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a behavioural model of the repair table.
module sim_spare_row_remap;

    localparam int NB   = 4;
    localparam int RW   = 10;
    localparam int SP   = 4;
    localparam int HE   = 2;
    localparam int CW   = 6;
    localparam int BW   = 2;
    localparam int SW   = 2;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          otp_blank = 1'b1;
    logic          act_valid = 1'b0;
    logic [BW-1:0] act_bank = '0;
    logic [RW-1:0] act_row = '0;
    logic          row_sel_en, spare_sel_en, spare_is_hard;
    logic [SW-1:0] spare_idx;
    logic [BW-1:0] sel_bank;
    logic [RW-1:0] sel_row;
    logic          prog_valid = 1'b0, prog_hard = 1'b0, prog_clear = 1'b0;
    logic [BW-1:0] prog_bank = '0;
    logic [RW-1:0] prog_row = '0;
    logic          prog_done, prog_err;
    logic [2:0]    rd_sel = '0;
    logic [BW-1:0] rd_bank = '0;
    logic [CW-1:0] rd_data;

    always #5 clk = ~clk;

    spare_row_remap #(
        .NUM_BANKS(NB), .ROW_W(RW), .SOFT_PER_BANK(SP),
        .HARD_ENTRIES(HE), .CNT_W(CW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .otp_blank(otp_blank),
        .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
        .row_sel_en(row_sel_en), .spare_sel_en(spare_sel_en),
        .spare_is_hard(spare_is_hard), .spare_idx(spare_idx),
        .sel_bank(sel_bank), .sel_row(sel_row),
        .prog_valid(prog_valid), .prog_hard(prog_hard), .prog_clear(prog_clear),
        .prog_bank(prog_bank), .prog_row(prog_row),
        .prog_done(prog_done), .prog_err(prog_err),
        .rd_sel(rd_sel), .rd_bank(rd_bank), .rd_data(rd_data)
    );

    // Behavioural model state.
    bit m_svld [NB][SP];
    int m_srow [NB][SP];
    bit m_hvld [HE];
    int m_hbank [HE];
    int m_hrow [HE];
    int m_hcnt, m_scnt;

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int hard_find(input int b, input int r);
        for (int i = 0; i < HE; i++)
            if (m_hvld[i] && m_hbank[i] == b && m_hrow[i] == r) return i;
        return -1;
    endfunction

    function automatic int soft_find(input int b, input int r);
        for (int s = 0; s < SP; s++)
            if (m_svld[b][s] && m_srow[b][s] == r) return s;
        return -1;
    endfunction

    function automatic int soft_used(input int b);
        int n = 0;
        for (int s = 0; s < SP; s++) if (m_svld[b][s]) n++;
        return n;
    endfunction

    function automatic int hard_used();
        int n = 0;
        for (int i = 0; i < HE; i++) if (m_hvld[i]) n++;
        return n;
    endfunction

    task automatic act(input int b, input int r, input string tag);
        int h = hard_find(b, r);
        int s = soft_find(b, r);
        int hit = (h >= 0 || s >= 0) ? 1 : 0;
        int idx = (h >= 0) ? h : s;
        @(negedge clk);
        act_valid = 1'b1; act_bank = BW'(b); act_row = RW'(r);
        @(negedge clk);
        act_valid = 1'b0;
        chk({tag, " row_sel_en"}, int'(row_sel_en), 1 - hit);
        chk({tag, " spare_sel_en"}, int'(spare_sel_en), hit);
        chk({tag, " spare_is_hard"}, int'(spare_is_hard), (h >= 0) ? 1 : 0);
        if (hit != 0) chk({tag, " spare_idx"}, int'(spare_idx), idx);
        chk({tag, " sel_row R2"}, int'(sel_row), r);
        chk({tag, " sel_bank R2"}, int'(sel_bank), b);
        if (h >= 0)      begin if (m_hcnt < CMAX) m_hcnt++; end
        else if (s >= 0) begin if (m_scnt < CMAX) m_scnt++; end
    endtask

    task automatic prog(input bit hard, input bit clr, input int b, input int r,
                        input string tag);
        int ok = 0;
        if (hard && !clr) begin
            if (hard_find(b, r) < 0) begin
                for (int i = 0; i < HE; i++)
                    if (!m_hvld[i] && ok == 0) begin
                        m_hvld[i] = 1; m_hbank[i] = b; m_hrow[i] = r; ok = 1;
                    end
            end
        end else if (!hard && !clr) begin
            if (soft_find(b, r) >= 0) ok = 1;
            else begin
                for (int s = 0; s < SP; s++)
                    if (!m_svld[b][s] && ok == 0) begin
                        m_svld[b][s] = 1; m_srow[b][s] = r; ok = 1;
                    end
            end
        end else if (!hard && clr) begin
            int s = soft_find(b, r);
            if (s >= 0) begin m_svld[b][s] = 0; ok = 1; end
        end
        @(negedge clk);
        prog_valid = 1'b1; prog_hard = hard; prog_clear = clr;
        prog_bank = BW'(b); prog_row = RW'(r);
        @(negedge clk);
        prog_valid = 1'b0;
        chk({tag, " prog_done R11"}, int'(prog_done), ok);
        chk({tag, " prog_err R11"}, int'(prog_err), 1 - ok);
    endtask

    task automatic rd(input int sel, input int b, input int exp, input string tag);
        @(negedge clk);
        rd_sel = 3'(sel); rd_bank = BW'(b);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic status(input string tag);
        rd(0, 0, hard_used(), {tag, " R9 hard used"});
        rd(1, 0, HE - hard_used(), {tag, " R9 hard free"});
        for (int b = 0; b < NB; b++) begin
            rd(2, b, soft_used(b), {tag, " R9 soft used"});
            rd(3, b, SP - soft_used(b), {tag, " R9 soft free"});
        end
        rd(4, 0, m_hcnt, {tag, " R10 hard hits"});
        rd(5, 0, m_scnt, {tag, " R10 soft hits"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < SP; s++) m_svld[b][s] = 0;
        m_hcnt = 0; m_scnt = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(10 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1; otp_blank = 1'b0;

        // Reset state.
        chk("R1 reset row_sel_en", int'(row_sel_en), 0);
        chk("R11 reset prog_done", int'(prog_done), 0);
        status("reset R5");

        // Miss, then the first soft entry.
        act(1, 5, "R2 miss");
        prog(0, 0, 1, 5, "R6 first soft");
        act(1, 5, "R6 soft hit slot0");
        act(2, 5, "R1 bank differs");
        act(1, 4, "R1 row differs");
        prog(0, 0, 1, 5, "R6 rewrite same");
        rd(2, 1, 1, "R6 used stays one");

        // Fill bank 1, then overflow.
        prog(0, 0, 1, 6, "R6 slot1");
        prog(0, 0, 1, 7, "R6 slot2");
        prog(0, 0, 1, 8, "R6 slot3");
        act(1, 8, "R6 soft hit slot3");
        prog(0, 0, 1, 9, "R7 full reject");
        rd(2, 1, SP, "R7 used unchanged");
        act(1, 9, "R7 rejected row misses");

        // Release and reuse.
        prog(0, 1, 1, 6, "R5 release");
        prog(0, 1, 1, 6, "R5 release absent");
        prog(0, 0, 1, 9, "R5 reuse freed slot");
        act(1, 9, "R5 reuse hit slot1");

        // Hard entry over a soft one.
        prog(1, 0, 1, 5, "R8 first hard");
        act(1, 5, "R3 hard over soft");
        prog(1, 0, 1, 5, "R4 hard duplicate");
        prog(1, 1, 1, 5, "R4 hard clear");
        status("mid R10");

        // Reset keeps hard, drops soft.
        do_reset();
        act(1, 5, "R4 hard survives reset");
        act(1, 7, "R5 soft gone after reset");
        status("post reset R5");
        prog(1, 0, 3, 1, "R8 second hard idx1");
        act(3, 1, "R8 hard idx1 hit");
        prog(1, 0, 0, 2, "R8 fuses exhausted");
        act(0, 2, "R8 rejected hard misses");
        rd(1, 0, 0, "R9 hard free zero");

        // Seeded random traffic on a small address set.
        for (int n = 0; n < 400; n++) begin
            int op = $urandom % 20;
            int b = $urandom % NB;
            int r = $urandom % 8;
            if (op < 12)      act(b, r, "R1 random act");
            else if (op < 16) prog(0, 0, b, r, "R6 random soft write");
            else if (op < 19) prog(0, 1, b, r, "R5 random soft clear");
            else              do_reset();
        end
        status("random R9");

        // Saturation of the hard hit counter.
        for (int n = 0; n < CMAX + 8; n++) act(1, 5, "R10 hard hit run");
        rd(4, 0, CMAX, "R10 hard counter saturates");
        status("final R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule